// File: doc/BRIEF.md
# Dual-CPU Interrupt Router with Shadow Gating

This block routes up to 32 level-sensitive interrupt inputs onto two CPU interrupt lines. Every input has an enable bit and a single steering bit. The steering bit sends the input to CPU0 when clear and to CPU1 when set. Software reaches the enable and steering words, and a per-CPU pending word, through a small register port. Each CPU receives one level line, which is the OR of its pending word.

Some inputs are per-CPU sources, and both processors must be able to receive them. A single steering bit cannot deliver to two targets, so each such source is tied at build time to a shadow input number. The shadow input never raises an interrupt of its own. Its enable bit acts as the CPU1 gate for the tied source. The source's own enable and steering bits still govern its CPU0 delivery. The pairs are a parameter list of (shadow, source) indices, and the default list is the single pair (30, 31).

Top module: `irq_dual_route`

## Requirements
- R1: After a synchronous reset the enable word and the steering word read 0, both pending words read 0, and both CPU lines are low.
- R2: A write at offset 0 loads the enable word (1 = enabled) and a write at offset 1 loads the steering word (1 = CPU1). Both read back at the same offsets. Writes to offsets 2 and 3 change neither word.
- R3: An input that is neither a shadow nor a paired source is pending for at most one CPU: for CPU0 when it is enabled with steering 0, and for CPU1 when it is enabled with steering 1.
- R4: An input whose enable bit is 0 is pending for neither CPU, unless it is a paired source whose shadow is enabled (see R7).
- R5: A shadow input is never pending for either CPU, whatever its level, enable and steering bits.
- R6: A paired source is pending for CPU0 exactly when it is high, its own enable bit is 1 and its steering bit is 0.
- R7: A paired source is pending for CPU1 exactly when it is high and its shadow's enable bit is 1. Its own enable and steering bits have no effect on CPU1. With the default pair, clearing enable bit 30 stops input 31 from reaching CPU1.
- R8: Offset 2 reads the CPU0 pending word and offset 3 reads the CPU1 pending word, one bit per input.
- R9: Each pending word is registered from the current inputs and settings. Each CPU line is the OR of its pending word, so a line changes on the first clock edge after the change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | 32 | Interrupt input levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 enable, 1 steering, 2 CPU0 pending, 3 CPU1 pending |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the word at reg_addr, combinational |
| irq_cpu0 | output | 1 | Level interrupt to CPU0 |
| irq_cpu1 | output | 1 | Level interrupt to CPU1 |

## Verification
The assertions assume that the interrupt inputs are synchronous to the clock and that the pair list names distinct, in-range indices, with no index used both as a shadow and as a source. The bench drives all inputs half a cycle away from the active edge and keeps the default pair. Its random stimulus covers every input level, enable and steering value, including shadow-only and source-only combinations. Directed cases cover the reset state, writes to the read-only offsets, and the one-edge delay of the CPU lines.

// File: rtl/irq_dual_route.sv
module irq_dual_route #(
  parameter int N = 32,
  parameter int NPAIR = 1,
  parameter int IW = $clog2(N),
  parameter logic [NPAIR*IW-1:0] SHADOW_LIST = (NPAIR*IW)'(30),
  parameter logic [NPAIR*IW-1:0] SOURCE_LIST = (NPAIR*IW)'(31)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] irq_in,
  input  logic         reg_we,
  input  logic [1:0]   reg_addr,
  input  logic [N-1:0] reg_wdata,
  output logic [N-1:0] reg_rdata,
  output logic         irq_cpu0,
  output logic         irq_cpu1
);

  logic [N-1:0] mask_q, aff_q, pend0_q, pend1_q;
  logic [N-1:0] shadow_bits, paired, sh_en, en0, en1;

  always_comb begin
    shadow_bits = '0;
    paired      = '0;
    sh_en       = '0;
    for (int p = 0; p < NPAIR; p++) begin
      shadow_bits[SHADOW_LIST[p*IW +: IW]] = 1'b1;
      paired[SOURCE_LIST[p*IW +: IW]]      = 1'b1;
      sh_en[SOURCE_LIST[p*IW +: IW]]       = mask_q[SHADOW_LIST[p*IW +: IW]];
    end
  end

  assign en0 = mask_q & ~aff_q & ~shadow_bits;
  assign en1 = ~shadow_bits & ((mask_q & aff_q & ~paired) | sh_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      aff_q   <= '0;
      pend0_q <= '0;
      pend1_q <= '0;
    end else begin
      if (reg_we && reg_addr == 2'd0) mask_q <= reg_wdata;
      if (reg_we && reg_addr == 2'd1) aff_q  <= reg_wdata;
      pend0_q <= irq_in & en0;
      pend1_q <= irq_in & en1;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = mask_q;
      2'd1:    reg_rdata = aff_q;
      2'd2:    reg_rdata = pend0_q;
      default: reg_rdata = pend1_q;
    endcase
  end

  assign irq_cpu0 = |pend0_q;
  assign irq_cpu1 = |pend1_q;

endmodule

module irq_dual_route_chk #(
  parameter int N = 32,
  parameter int NPAIR = 1,
  parameter int IW = $clog2(N),
  parameter logic [NPAIR*IW-1:0] SHADOW_LIST = (NPAIR*IW)'(30),
  parameter logic [NPAIR*IW-1:0] SOURCE_LIST = (NPAIR*IW)'(31)
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] irq_in,
  input logic         reg_we,
  input logic [1:0]   reg_addr,
  input logic [N-1:0] reg_rdata,
  input logic         irq_cpu0,
  input logic         irq_cpu1,
  input logic [N-1:0] mask_q,
  input logic [N-1:0] aff_q,
  input logic [N-1:0] pend0_q,
  input logic [N-1:0] pend1_q
);
  logic live;
  logic [N-1:0] shm, prd, gate1;

  always_ff @(posedge clk) live <= !rst;

  always_comb begin
    shm = '0;
    prd = '0;
    gate1 = '0;
    for (int p = 0; p < NPAIR; p++) begin
      shm[SHADOW_LIST[p*IW +: IW]] = 1'b1;
      prd[SOURCE_LIST[p*IW +: IW]] = 1'b1;
      gate1[SOURCE_LIST[p*IW +: IW]] = mask_q[SHADOW_LIST[p*IW +: IW]];
    end
  end

  a_r3_single_target: assert property (@(posedge clk) disable iff (rst)
    live |-> ((pend0_q & pend1_q & ~prd) == '0));
  a_r5_shadow_silent: assert property (@(posedge clk) disable iff (rst)
    live |-> (((pend0_q | pend1_q) & shm) == '0));
  a_r9_cpu0_delay: assert property (@(posedge clk) disable iff (rst)
    live |-> (irq_cpu0 == |$past(irq_in & mask_q & ~aff_q & ~shm)));
  a_r7_cpu1_delay: assert property (@(posedge clk) disable iff (rst)
    live |-> (irq_cpu1 == |$past(irq_in & ~shm & ((mask_q & aff_q & ~prd) | gate1))));
  a_r2_mask_hold: assert property (@(posedge clk) disable iff (rst)
    (live && !(reg_we && reg_addr == 2'd0)) |=> $stable(mask_q));
  a_r2_aff_hold: assert property (@(posedge clk) disable iff (rst)
    (live && !(reg_we && reg_addr == 2'd1)) |=> $stable(aff_q));
  a_r8_pend_read: assert property (@(posedge clk) disable iff (rst)
    (live && reg_addr == 2'd3) |-> (reg_rdata == pend1_q));
endmodule

bind irq_dual_route irq_dual_route_chk #(
  .N(N), .NPAIR(NPAIR), .IW(IW), .SHADOW_LIST(SHADOW_LIST), .SOURCE_LIST(SOURCE_LIST)
) u_chk (
  .clk(clk), .rst(rst), .irq_in(irq_in), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .irq_cpu0(irq_cpu0), .irq_cpu1(irq_cpu1),
  .mask_q(mask_q), .aff_q(aff_q), .pend0_q(pend0_q), .pend1_q(pend1_q)
);

// File: tb/tb_irq_dual_route.sv
module tb_irq_dual_route;
  localparam int SH = 30;
  localparam int SRC = 31;

  logic        clk = 0;
  logic        rst = 1;
  logic [31:0] irq_in = '0;
  logic        reg_we = 0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_cpu0, irq_cpu1;

  int checks = 0, fails = 0;
  logic [31:0] m_mask = '0, m_aff = '0, m_in = '0;

  irq_dual_route dut (.clk(clk), .rst(rst), .irq_in(irq_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_cpu0(irq_cpu0), .irq_cpu1(irq_cpu1));

  always #5 clk = ~clk;

  function automatic logic [31:0] exp0(logic [31:0] i, logic [31:0] m, logic [31:0] a);
    logic [31:0] r = i & m & ~a;
    r[SH] = 1'b0;
    return r;
  endfunction

  function automatic logic [31:0] exp1(logic [31:0] i, logic [31:0] m, logic [31:0] a);
    logic [31:0] r = i & m & a;
    r[SH]  = 1'b0;
    r[SRC] = i[SRC] & m[SH];
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    if (a == 2'd0) m_mask = d;
    if (a == 2'd1) m_aff = d;
  endtask

  task automatic apply(logic [31:0] v, string tag);
    logic [31:0] d;
    @(negedge clk);
    irq_in = v;
    #1;
    chk({tag, " R9 cpu0 before edge"}, 32'(irq_cpu0), 32'(|exp0(m_in, m_mask, m_aff)));
    chk({tag, " R9 cpu1 before edge"}, 32'(irq_cpu1), 32'(|exp1(m_in, m_mask, m_aff)));
    m_in = v;
    @(negedge clk);
    chk({tag, " R9 cpu0 line"}, 32'(irq_cpu0), 32'(|exp0(v, m_mask, m_aff)));
    chk({tag, " R9 cpu1 line"}, 32'(irq_cpu1), 32'(|exp1(v, m_mask, m_aff)));
    rd(2'd2, d); chk({tag, " R8 R6 R3 cpu0 pending"}, d, exp0(v, m_mask, m_aff));
    rd(2'd3, d); chk({tag, " R8 R7 R3 cpu1 pending"}, d, exp1(v, m_mask, m_aff));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed));
    irq_in = '1;
    repeat (3) @(negedge clk);
    rst = 0;
    irq_in = '0;
    rd(2'd0, d); chk("R1 mask", d, '0);
    rd(2'd1, d); chk("R1 affinity", d, '0);
    rd(2'd2, d); chk("R1 pend0", d, '0);
    rd(2'd3, d); chk("R1 pend1", d, '0);
    chk("R1 lines", {30'd0, irq_cpu1, irq_cpu0}, '0);

    wr(2'd0, 32'hA5A5_0F0F); rd(2'd0, d); chk("R2 mask readback", d, 32'hA5A5_0F0F);
    wr(2'd1, 32'h1234_5678); rd(2'd1, d); chk("R2 affinity readback", d, 32'h1234_5678);
    wr(2'd2, 32'hFFFF_FFFF); wr(2'd3, 32'h0);
    rd(2'd0, d); chk("R2 mask after ro writes", d, 32'hA5A5_0F0F);
    rd(2'd1, d); chk("R2 affinity after ro writes", d, 32'h1234_5678);

    // R4: disabled inputs stay quiet
    wr(2'd0, 32'h0); wr(2'd1, 32'h0);
    apply(32'h7FFF_FFFF, "R4 all disabled");
    // R5: shadow alone, fully enabled either way
    wr(2'd0, 32'hFFFF_FFFF);
    apply(32'h4000_0000, "R5 shadow cpu0 side");
    wr(2'd1, 32'hFFFF_FFFF);
    apply(32'h4000_0000, "R5 shadow cpu1 side");
    // R7: source reaches CPU1 through shadow enable only
    wr(2'd0, 32'h4000_0000); wr(2'd1, 32'h0);
    apply(32'h8000_0000, "R7 shadow gate on");
    wr(2'd0, 32'h8000_0000); wr(2'd1, 32'h8000_0000);
    apply(32'h8000_0000, "R7 shadow gate off");
    // R6: source to CPU0 and CPU1 at once
    wr(2'd0, 32'hC000_0000); wr(2'd1, 32'h0);
    apply(32'h8000_0000, "R6 dual delivery");
    apply(32'h0, "R6 source low");
    // R3: steering of ordinary inputs
    wr(2'd0, 32'h0000_00FF); wr(2'd1, 32'h0000_000F);
    apply(32'h0000_0011, "R3 split");

    for (int k = 0; k < 250; k++) begin
      if ($urandom_range(0, 3) == 0) wr(2'd0, $urandom);
      if ($urandom_range(0, 3) == 0) wr(2'd1, $urandom);
      apply($urandom, "rand");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule